// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block is the part of an interrupt distributor that turns a single 32-bit register write from a CPU into software-generated interrupts. The written word carries three fields: a 4-bit interrupt number, a target filter mode, and an 8-bit list of target CPUs. The writing CPU's index comes in on the write port, and a static input gives the number of CPUs that are populated.

For every CPU selected by the filter, the block sets a pending flag for that interrupt number. It also records the writer in a per-target, per-interrupt source bitmap. An acknowledgement port removes one source bit at a time. A pending flag stays set until the last source behind it has been acknowledged.

The register port is plain. There is no valid/ready handshake and no back-pressure: every strobed write is taken in the cycle it appears, and a read always returns zero. Priority arbitration and delivery to the CPU interfaces are handled elsewhere.

Top module: `sgi_dispatch`

## Requirements
- R1: The interrupt number is taken from bits [3:0] of the written word, which gives 16 numbers. The state of target t and number n appears at `pend_o[t*16+n]` and at `src_o[(t*16+n)*8 +: 8]`. In that 8-bit slice, bit s is set when CPU s raised the interrupt.
- R2: Mode field bits [25:24] = 0 targets exactly the CPUs in list bits [23:16]. List bits at or above `cpu_count` are discarded.
- R3: Mode 1 targets every CPU below `cpu_count` except the writer.
- R4: Mode 2 targets only the writer, whatever the list holds.
- R5: A write with mode 3 changes no pending or source state.
- R6: A write whose byte enable is not 4'hF changes no pending or source state.
- R7: For each targeted CPU, the pending flag of the decoded number is set, and source bit `wr_cpu` is set in its bitmap. Bits already set are kept.
- R8: `rd_data` is always zero.
- R9: An acknowledgement (`clr_cpu`, `clr_id`, `clr_src`) clears only that one source bit. The pending flag stays set while any other source bit remains.
- R10: A pending flag is clear exactly when its source bitmap is empty.
- R11: Updates are visible in the cycle after the write or acknowledgement strobe, and not before.
- R12: When a write and an acknowledgement hit the same source bit in the same cycle, the bit ends up set.
- R13: Reset clears all pending flags and all source bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cpu_count | input | 4 | Number of populated CPUs (0..8) |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Written word |
| wr_cpu | input | 3 | Index of the writing CPU |
| rd_data | output | 32 | Read data, always zero |
| clr_en | input | 1 | Acknowledge strobe |
| clr_cpu | input | 3 | Target CPU of the acknowledged interrupt |
| clr_id | input | 4 | Interrupt number being acknowledged |
| clr_src | input | 3 | Source bit to remove |
| pend_o | output | 128 | Pending flags, one per target and number |
| src_o | output | 1024 | Source bitmaps, 8 bits per target and number |

## Verification
The assertions check four properties on every cycle:
- a pending flag always agrees with its bitmap;
- a hit source bit is set one cycle later, and this holds even under a simultaneous clear;
- a lone clear drops its bit;
- idle, reserved-mode and partial-width writes leave all state frozen, and modes 0 and 1 never select a CPU at or above the count.

Only the bench's scenarios can show the rest: that each mode selects the correct set of targets, that sources from several writers accumulate and drain in the right order, that the bitmaps are placed at the documented output positions, and that nothing is visible in the cycle of the strobe itself.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int MAX_CPUS  = 8;
  localparam int NUM_IDS   = 16;
  localparam int WORD_W    = 32;
  localparam int CPU_W     = $clog2(MAX_CPUS);
  localparam int CNT_W     = $clog2(MAX_CPUS + 1);
  localparam int ID_W      = $clog2(NUM_IDS);

  // field positions inside the written word
  localparam int ID_LSB    = 0;
  localparam int LIST_LSB  = 16;
  localparam int MODE_LSB  = 24;

  typedef enum logic [1:0] {
    FILT_LIST      = 2'd0,
    FILT_OTHERS    = 2'd1,
    FILT_SELF      = 2'd2,
    FILT_RESERVED  = 2'd3
  } filt_mode_e;
endpackage

// File: rtl/sgi_decode.sv
module sgi_decode
  import sgi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_be,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [CPU_W-1:0]  wr_cpu,
  input  logic [CNT_W-1:0]  cpu_count,
  output logic              fire,
  output logic [ID_W-1:0]   id,
  output logic [MAX_CPUS-1:0] mask
);
  filt_mode_e           mode;
  logic [MAX_CPUS-1:0]  list;
  logic [MAX_CPUS-1:0]  populated;
  logic [MAX_CPUS-1:0]  self_bit;
  logic                 unused_fields;

  assign mode = filt_mode_e'(wr_data[MODE_LSB +: 2]);
  assign list = wr_data[LIST_LSB +: MAX_CPUS];
  assign id   = wr_data[ID_LSB +: ID_W];
  assign unused_fields = ^{wr_data[LIST_LSB-1:ID_LSB+ID_W], wr_data[WORD_W-1:MODE_LSB+2]};

  always_comb begin
    for (int c = 0; c < MAX_CPUS; c++) begin
      populated[c] = (CNT_W'(c) < cpu_count);
      self_bit[c]  = (CPU_W'(c) == wr_cpu);
    end
  end

  always_comb begin
    unique case (mode)
      FILT_LIST:   mask = list & populated;
      FILT_OTHERS: mask = populated & ~self_bit;
      FILT_SELF:   mask = self_bit;
      default:     mask = '0;
    endcase
  end

  assign fire = wr_en && (wr_be == 4'hF) && (mode != FILT_RESERVED);

  // R2
  mask_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wr_data[MODE_LSB +: 2] != 2'd2) |-> ((mask >> cpu_count) == '0));
endmodule

// File: rtl/sgi_cell.sv
module sgi_cell
  import sgi_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_i,
  input  logic [CPU_W-1:0]    set_src,
  input  logic                clr_i,
  input  logic [CPU_W-1:0]    clr_src,
  output logic                pend_o,
  output logic [MAX_CPUS-1:0] src_o
);
  logic [MAX_CPUS-1:0] src_q, src_d;
  logic                pend_q;

  always_comb begin
    src_d = src_q;
    if (clr_i) src_d[clr_src] = 1'b0;
    if (set_i) src_d[set_src] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      src_q  <= src_d;
      pend_q <= |src_d;
    end
  end

  assign pend_o = pend_q;
  assign src_o  = src_q;

  // R7 R12
  src_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> (pend_q && src_q[$past(set_src)]));

  // R9
  clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !src_q[$past(clr_src)]);

  // R10
  pend_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q == (src_q != '0));
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [CNT_W-1:0]                   cpu_count,
  input  logic                               wr_en,
  input  logic [3:0]                         wr_be,
  input  logic [WORD_W-1:0]                  wr_data,
  input  logic [CPU_W-1:0]                   wr_cpu,
  output logic [WORD_W-1:0]                  rd_data,
  input  logic                               clr_en,
  input  logic [CPU_W-1:0]                   clr_cpu,
  input  logic [ID_W-1:0]                    clr_id,
  input  logic [CPU_W-1:0]                   clr_src,
  output logic [MAX_CPUS*NUM_IDS-1:0]        pend_o,
  output logic [MAX_CPUS*NUM_IDS*MAX_CPUS-1:0] src_o
);
  logic                fire;
  logic [ID_W-1:0]     id;
  logic [MAX_CPUS-1:0] mask;

  sgi_decode u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .wr_cpu(wr_cpu), .cpu_count(cpu_count),
    .fire(fire), .id(id), .mask(mask)
  );

  for (genvar t = 0; t < MAX_CPUS; t++) begin : g_tgt
    for (genvar n = 0; n < NUM_IDS; n++) begin : g_id
      localparam int K = t*NUM_IDS + n;
      sgi_cell u_cell (
        .clk(clk), .rst_n(rst_n),
        .set_i(fire && mask[t] && (id == ID_W'(n))),
        .set_src(wr_cpu),
        .clr_i(clr_en && (clr_cpu == CPU_W'(t)) && (clr_id == ID_W'(n))),
        .clr_src(clr_src),
        .pend_o(pend_o[K]),
        .src_o(src_o[K*MAX_CPUS +: MAX_CPUS])
      );
    end
  end

  assign rd_data = '0;

  // R5 R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!wr_en || wr_be != 4'hF || wr_data[MODE_LSB +: 2] == 2'd3) && !clr_en)
      |=> ($stable(pend_o) && $stable(src_o)));
endmodule

// File: tb/test_sgi_dispatch.sv
module test_sgi_dispatch;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   cpu_count = 4'd8;
  logic         wr_en = 1'b0;
  logic [3:0]   wr_be = 4'h0;
  logic [31:0]  wr_data = '0;
  logic [2:0]   wr_cpu = '0;
  logic [31:0]  rd_data;
  logic         clr_en = 1'b0;
  logic [2:0]   clr_cpu = '0;
  logic [3:0]   clr_id = '0;
  logic [2:0]   clr_src = '0;
  logic [127:0] pend_o;
  logic [1023:0] src_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sgi_dispatch i_sgi_dispatch (
    .clk(clk), .rst_n(rst_n), .cpu_count(cpu_count), .wr_en(wr_en),
    .wr_be(wr_be), .wr_data(wr_data), .wr_cpu(wr_cpu), .rd_data(rd_data),
    .clr_en(clr_en), .clr_cpu(clr_cpu), .clr_id(clr_id), .clr_src(clr_src),
    .pend_o(pend_o), .src_o(src_o)
  );

  function automatic logic [31:0] word(input logic [1:0] mode, input logic [7:0] list,
                                       input logic [3:0] id);
    return {6'b0, mode, list, 12'b0, id};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive at negedge; state visible at the following negedge
  task automatic strobe(input bit we, input logic [2:0] cpu, input logic [3:0] be,
                        input logic [31:0] d, input bit ce, input logic [2:0] ct,
                        input logic [3:0] ci, input logic [2:0] cs);
    @(negedge clk);
    wr_en = we; wr_cpu = cpu; wr_be = be; wr_data = d;
    clr_en = ce; clr_cpu = ct; clr_id = ci; clr_src = cs;
    @(negedge clk);
    wr_en = 1'b0; clr_en = 1'b0;
  endtask

  function automatic logic [7:0] srcs(input int t, input int n);
    return src_o[(t*16+n)*8 +: 8];
  endfunction

  // {writer[2:0], count[3:0], be[3:0], data[31:0], expected targets[7:0]}
  localparam int NV = 8;
  localparam logic [50:0] VEC [NV] = '{
    {3'd0, 4'd8, 4'hF, {6'b0, 2'd0, 8'h0A, 12'b0, 4'd3},  8'h0A}, // R2
    {3'd2, 4'd4, 4'hF, {6'b0, 2'd0, 8'hFF, 12'b0, 4'd15}, 8'h0F}, // R2
    {3'd1, 4'd4, 4'hF, {6'b0, 2'd1, 8'h00, 12'b0, 4'd5},  8'h0D}, // R3
    {3'd7, 4'd8, 4'hF, {6'b0, 2'd1, 8'h80, 12'b0, 4'd9},  8'h7F}, // R3
    {3'd6, 4'd8, 4'hF, {6'b0, 2'd2, 8'hF0, 12'b0, 4'd0},  8'h40}, // R4
    {3'd3, 4'd8, 4'hF, {6'b0, 2'd3, 8'hFF, 12'b0, 4'd2},  8'h00}, // R5
    {3'd0, 4'd8, 4'h7, {6'b0, 2'd0, 8'hFF, 12'b0, 4'd1},  8'h00}, // R6
    {3'd0, 4'd1, 4'hF, {6'b0, 2'd1, 8'hFF, 12'b0, 4'd4},  8'h00}  // R3
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    check("R13 pend", 64'(pend_o != '0), 64'd0);
    check("R13 src", 64'(src_o != '0), 64'd0);
    // R8
    check("R8 rd_data", 64'(rd_data), 64'd0);

    for (int v = 0; v < NV; v++) begin
      logic [2:0] wcpu;
      logic [3:0] wcnt, wbe, wid;
      logic [31:0] wd;
      logic [7:0] exp_t;
      {wcpu, wcnt, wbe, wd, exp_t} = VEC[v];
      wid = wd[3:0];
      do_reset();
      cpu_count = wcnt;
      strobe(1'b1, wcpu, wbe, wd, 1'b0, 3'd0, 4'd0, 3'd0);
      for (int t = 0; t < 8; t++) begin
        // R1 R7 pending flag and writer's source bit at the documented slot
        check($sformatf("R7 vec%0d tgt%0d", v, t),
              {62'd0, pend_o[t*16+wid], srcs(t, wid) == (exp_t[t] ? (8'h1 << wcpu) : 8'h0)},
              {62'd0, exp_t[t], 1'b1});
      end
      check($sformatf("R1 vec%0d popcount", v), 64'($countones(pend_o)), 64'($countones(exp_t)));
    end

    cpu_count = 4'd8;
    do_reset();
    // R11 nothing visible before the edge
    @(negedge clk);
    wr_en = 1'b1; wr_cpu = 3'd0; wr_be = 4'hF; wr_data = word(2'd0, 8'h20, 4'd9);
    #5;
    check("R11 before edge", 64'(pend_o != '0), 64'd0);
    @(negedge clk);
    wr_en = 1'b0;
    check("R11 after edge", 64'(pend_o[5*16+9]), 64'd1);
    // R7 second writer accumulates
    strobe(1'b1, 3'd3, 4'hF, word(2'd0, 8'h20, 4'd9), 1'b0, 3'd0, 4'd0, 3'd0);
    check("R7 accumulate", 64'(srcs(5, 9)), 64'h09);
    // R9 clear one source, pending stays
    strobe(1'b0, 3'd0, 4'h0, '0, 1'b1, 3'd5, 4'd9, 3'd0);
    check("R9 one bit", 64'({pend_o[5*16+9], srcs(5, 9)}), 64'h108);
    // R10 clear last source, pending drops
    strobe(1'b0, 3'd0, 4'h0, '0, 1'b1, 3'd5, 4'd9, 3'd3);
    check("R10 empty", 64'({pend_o[5*16+9], srcs(5, 9)}), 64'h000);

    // R12 set wins over a same-cycle clear
    strobe(1'b1, 3'd2, 4'hF, word(2'd0, 8'h02, 4'd4), 1'b0, 3'd0, 4'd0, 3'd0);
    strobe(1'b1, 3'd2, 4'hF, word(2'd0, 8'h02, 4'd4), 1'b1, 3'd1, 4'd4, 3'd2);
    check("R12 set wins", 64'({pend_o[1*16+4], srcs(1, 4)}), 64'h104);
    // R9 clear at another target/ID has no effect here
    strobe(1'b0, 3'd0, 4'h0, '0, 1'b1, 3'd1, 4'd5, 3'd2);
    check("R9 other id", 64'({pend_o[1*16+4], srcs(1, 4)}), 64'h104);
    // R6 partial write leaves state untouched
    strobe(1'b1, 3'd0, 4'hC, word(2'd0, 8'hFF, 4'd4), 1'b0, 3'd0, 4'd0, 3'd0);
    check("R6 partial", 64'($countones(pend_o)), 64'd1);
    // R5 reserved mode leaves state untouched
    strobe(1'b1, 3'd0, 4'hF, word(2'd3, 8'hFF, 4'd4), 1'b0, 3'd0, 4'd0, 3'd0);
    check("R5 reserved", 64'($countones(src_o)), 64'd1);
    check("R8 rd_data busy", 64'(rd_data), 64'd0);
    // R13 reset clears live state
    do_reset();
    check("R13 re-reset", 64'(pend_o != '0 || src_o != '0), 64'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule